// File: doc/BRIEF.md
# Frame Buffer Load/Drain Controller

This block moves whole frames of complex samples into and out of a transform engine that processes blocks of `N` samples. On the load side it raises a ready flag and writes each qualified sample into one half of a two-bank input store. A frame is `N` samples. The two banks alternate from frame to frame, so the next frame can fill one bank while the engine still holds the other. Sample activity is ignored while the ready flag is low. The block also reports when the engine is working out of the second (pong) bank.

On the drain side, a frame-ready flag rises once the engine has placed its results in the output store. The host then pulls the results out with a read-enable that works as an output clock enable. Each cycle the enable is high, one result is issued one clock later, marked by a valid strobe. The host may pause at any point. After the last result of a frame, the frame-ready flag drops and the read pointer wraps to zero.

A stand-in engine holds each frame for a fixed latency and then copies it unchanged into the output store. An asynchronous active-low reset and a synchronous start pulse both return the block to its initial state.

Top module: `frame_xchg_ctrl`

## Requirements
- R1: After reset or a start pulse, the pointers are zero, `load_rdy_o` is 1, and `dout_rdy_o`, `dout_vld_o` and `pong_o` are 0.
- R2: On each rising edge where `din_vld_i` and `load_rdy_o` are both 1, one sample `{din_re_i, din_im_i}` is stored. Samples may be accepted on back-to-back edges.
- R3: While `load_rdy_o` is 0, `din_vld_i` and the sample inputs have no effect, and no such sample ever appears at the output.
- R4: The two input banks alternate per frame. `load_rdy_o` is 0 when the bank being filled already holds an unreleased frame. In particular, after three back-to-back frames with no reads, `load_rdy_o` is 0.
- R5: `dout_rdy_o` rises once the engine has written a frame's results. The results come out in the same order and with the same values as the samples were loaded, frame after frame.
- R6: `pong_o` is 1 exactly while the engine holds bank 1. For example, it is 1 while the third frame waits behind an undrained output, and 0 when the block is idle.
- R7: If `rd_en_i` and `dout_rdy_o` are 1 at an edge, `dout_vld_o` is 1 with the next result during the following cycle. Pauses in `rd_en_i` are allowed anywhere in a burst.
- R8: When the N-th result of a frame is issued, `dout_rdy_o` drops and the read pointer wraps to 0.
- R9: If `rd_en_i` is 1 while `dout_rdy_o` is 0, the edge has no effect, and `dout_vld_o` is 0 in the next cycle.
- R10: With `rd_en_i` held at 1, each frame appears as exactly `N` consecutive cycles of `dout_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous restart pulse |
| din_vld_i | input | 1 | Input sample qualifier |
| din_re_i | input | W | Input sample, real part |
| din_im_i | input | W | Input sample, imaginary part |
| load_rdy_o | output | 1 | Input side can take samples |
| pong_o | output | 1 | Engine works out of bank 1 |
| rd_en_i | input | 1 | Output clock enable from host |
| dout_rdy_o | output | 1 | A result frame is waiting to drain |
| dout_vld_o | output | 1 | Output sample valid |
| dout_re_o | output | W | Output sample, real part |
| dout_im_o | output | W | Output sample, imaginary part |

## Verification
A sample that is presented while `load_rdy_o` is high is taken at the next rising edge. The bench records it in a reference queue at the falling edge before that edge, and only when ready was high. The valid strobe is due exactly one edge after a read-enable seen together with frame-ready. The bench therefore stores the expected strobe at each falling edge and compares it, and the popped queue entry, at the next falling edge. Frame-ready and the bank indicator depend on the engine's latency, so they are checked only after waiting on the flags or after a settling interval long enough for any engine timing.

// File: rtl/frame_xchg_pkg.sv
package frame_xchg_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WAIT = 2'd1,
    ENG_COPY = 2'd2
  } eng_state_e;
endpackage

// File: rtl/fx_in_bank.sv
module fx_in_bank #(
  parameter int N = 16,
  parameter int W = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic [W-1:0]  re_i,
  input  logic [W-1:0]  im_i,
  input  logic          rel_i,
  input  logic          rel_bank_i,
  input  logic          rd_bank_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          load_rdy_o,
  output logic [1:0]    full_o,
  output logic [W-1:0]  rd_re_o,
  output logic [W-1:0]  rd_im_o,
  output logic [AW-1:0] wr_ptr_o
);
  logic [2*W-1:0] mem_q [2*N];
  logic [AW-1:0]  wr_ptr_q;
  logic           wr_bank_q;
  logic [1:0]     full_q, full_d;
  logic           accept;

  assign load_rdy_o = ~full_q[wr_bank_q];
  assign accept     = vld_i & load_rdy_o;
  assign full_o     = full_q;
  assign wr_ptr_o   = wr_ptr_q;

  // per-bank occupancy: set on last sample, cleared on engine release
  for (genvar b = 0; b < 2; b++) begin : g_full
    always_comb begin
      full_d[b] = full_q[b];
      if (accept && wr_bank_q == b[0] && wr_ptr_q == AW'(N-1)) full_d[b] = 1'b1;
      if (rel_i && rel_bank_i == b[0]) full_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      wr_bank_q <= 1'b0;
      full_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q  <= '0;
      wr_bank_q <= 1'b0;
      full_q    <= '0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
        if (wr_ptr_q == AW'(N-1)) wr_bank_q <= ~wr_bank_q;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept && !clr_i) mem_q[{wr_bank_q, wr_ptr_q}] <= {re_i, im_i};
  end

  assign {rd_re_o, rd_im_o} = mem_q[{rd_bank_i, rd_addr_i}];
endmodule

// File: rtl/fx_eng_stub.sv
module fx_eng_stub
  import frame_xchg_pkg::*;
#(
  parameter int N   = 16,
  parameter int LAT = 8,
  localparam int AW = $clog2(N),
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [1:0]    full_i,
  input  logic          out_busy_i,
  output logic          bank_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_en_o,
  output logic          done_o,
  output logic          pong_o
);
  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          bank_q;

  assign bank_o  = bank_q;
  assign addr_o  = addr_q;
  assign wr_en_o = (state_q == ENG_COPY);
  assign done_o  = (state_q == ENG_COPY) && (addr_q == AW'(N-1));
  assign pong_o  = (state_q != ENG_IDLE) && bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      bank_q  <= 1'b0;
    end else if (clr_i) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      bank_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (full_i[bank_q]) begin
          state_q <= ENG_WAIT;
          cnt_q   <= '0;
        end
        ENG_WAIT: begin
          // hold the bank until latency elapsed and output store is free
          if (cnt_q >= CW'(LAT-1) && !out_busy_i) begin
            state_q <= ENG_COPY;
            addr_q  <= '0;
          end else if (cnt_q < CW'(LAT-1)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ENG_COPY: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == AW'(N-1)) begin
            state_q <= ENG_IDLE;
            bank_q  <= ~bank_q;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fx_out_drain.sv
module fx_out_drain #(
  parameter int N = 16,
  parameter int W = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_re_i,
  input  logic [W-1:0]  wr_im_i,
  input  logic          done_i,
  input  logic          rd_en_i,
  output logic          rdy_o,
  output logic          vld_o,
  output logic [W-1:0]  re_o,
  output logic [W-1:0]  im_o,
  output logic [AW-1:0] rd_ptr_o
);
  logic [2*W-1:0] mem_q [N];
  logic [AW-1:0]  rd_ptr_q;
  logic           rdy_q, vld_q;
  logic [2*W-1:0] dat_q;
  logic           fire;

  assign fire     = rd_en_i & rdy_q;
  assign rdy_o    = rdy_q;
  assign vld_o    = vld_q;
  assign {re_o, im_o} = dat_q;
  assign rd_ptr_o = rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !clr_i) mem_q[wr_addr_i] <= {wr_re_i, wr_im_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      rdy_q    <= 1'b0;
      vld_q    <= 1'b0;
      dat_q    <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      rdy_q    <= 1'b0;
      vld_q    <= 1'b0;
      dat_q    <= '0;
    end else begin
      vld_q <= fire;
      if (fire) begin
        dat_q    <= mem_q[rd_ptr_q];
        rd_ptr_q <= rd_ptr_q + 1'b1;
        if (rd_ptr_q == AW'(N-1)) rdy_q <= 1'b0;
      end else if (done_i) begin
        rdy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_xchg_ctrl.sv
module frame_xchg_ctrl #(
  parameter int N   = 16,
  parameter int W   = 8,
  parameter int LAT = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         din_vld_i,
  input  logic [W-1:0] din_re_i,
  input  logic [W-1:0] din_im_i,
  output logic         load_rdy_o,
  output logic         pong_o,
  input  logic         rd_en_i,
  output logic         dout_rdy_o,
  output logic         dout_vld_o,
  output logic [W-1:0] dout_re_o,
  output logic [W-1:0] dout_im_o
);
  localparam int AW = $clog2(N);

  logic [1:0]    full;
  logic          eng_bank, eng_wr, eng_done;
  logic [AW-1:0] eng_addr, wr_ptr, rd_ptr;
  logic [W-1:0]  eng_re, eng_im;

  fx_in_bank #(.N(N), .W(W)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .vld_i      (din_vld_i),
    .re_i       (din_re_i),
    .im_i       (din_im_i),
    .rel_i      (eng_done),
    .rel_bank_i (eng_bank),
    .rd_bank_i  (eng_bank),
    .rd_addr_i  (eng_addr),
    .load_rdy_o (load_rdy_o),
    .full_o     (full),
    .rd_re_o    (eng_re),
    .rd_im_o    (eng_im),
    .wr_ptr_o   (wr_ptr)
  );

  fx_eng_stub #(.N(N), .LAT(LAT)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .full_i     (full),
    .out_busy_i (dout_rdy_o),
    .bank_o     (eng_bank),
    .addr_o     (eng_addr),
    .wr_en_o    (eng_wr),
    .done_o     (eng_done),
    .pong_o     (pong_o)
  );

  fx_out_drain #(.N(N), .W(W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .wr_en_i   (eng_wr),
    .wr_addr_i (eng_addr),
    .wr_re_i   (eng_re),
    .wr_im_i   (eng_im),
    .done_i    (eng_done),
    .rd_en_i   (rd_en_i),
    .rdy_o     (dout_rdy_o),
    .vld_o     (dout_vld_o),
    .re_o      (dout_re_o),
    .im_o      (dout_im_o),
    .rd_ptr_o  (rd_ptr)
  );
endmodule

// File: rtl/fx_chk.sv
module fx_chk #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          din_vld_i,
  input logic          rd_en_i,
  input logic          load_rdy_o,
  input logic          dout_rdy_o,
  input logic          dout_vld_o,
  input logic          pong_o,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr
);
  AST_CLR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> load_rdy_o && !dout_rdy_o && !dout_vld_o && !pong_o && wr_ptr == '0 && rd_ptr == '0); // R1

  AST_ACCEPT_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_vld_i && load_rdy_o && !start_i) |=> wr_ptr == AW'($past(wr_ptr) + 1'b1)); // R2

  AST_BLOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_rdy_o && !start_i) |=> $stable(wr_ptr)); // R3

  AST_READ_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && dout_rdy_o && !start_i) |=> dout_vld_o); // R7

  AST_READ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && dout_rdy_o) |=> !dout_vld_o); // R9

  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && dout_rdy_o && !start_i && rd_ptr == AW'(N-1)) |=> !dout_rdy_o && rd_ptr == '0); // R8
endmodule

bind frame_xchg_ctrl fx_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .din_vld_i  (din_vld_i),
  .rd_en_i    (rd_en_i),
  .load_rdy_o (load_rdy_o),
  .dout_rdy_o (dout_rdy_o),
  .dout_vld_o (dout_vld_o),
  .pong_o     (pong_o),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr)
);

// File: tb/frame_xchg_ctrl_tb_top.sv
module frame_xchg_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int W   = 8;
  localparam int NV  = 6;
  localparam logic [15:0] IN_PAT [NV] = '{16'hFFFF, 16'hAAAA, 16'h8421, 16'hF0F1, 16'h0101, 16'h7FFE};
  localparam logic [15:0] RD_PAT [NV] = '{16'hFFFF, 16'h5555, 16'h1111, 16'hFF00, 16'hC3A5, 16'h0001};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic din_vld = 1'b0, rd_en = 1'b0;
  logic [W-1:0] din_re = '0, din_im = '0;
  logic load_rdy, pong, dout_rdy, dout_vld;
  logic [W-1:0] dout_re, dout_im;

  int checks = 0, fails = 0;
  int acc_cnt = 0, out_cnt = 0, tgt_in = 0, tgt_out = 0;
  int run_len = 0, last_run = 0;
  bit exp_vld = 1'b0;
  logic [2*W-1:0] ref_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_xchg_ctrl #(.N(N), .W(W), .LAT(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .din_vld_i(din_vld), .din_re_i(din_re), .din_im_i(din_im),
    .load_rdy_o(load_rdy), .pong_o(pong), .rd_en_i(rd_en),
    .dout_rdy_o(dout_rdy), .dout_vld_o(dout_vld),
    .dout_re_o(dout_re), .dout_im_o(dout_im)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: data order (R5), read latency (R7, R9), run length (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(dout_vld == exp_vld, "R7/R9 valid timing", dout_vld, exp_vld);
      if (dout_vld) begin
        out_cnt++;
        run_len++;
        if (ref_q.size() == 0) chk(1'b0, "R5 unexpected output", {dout_re, dout_im}, 0);
        else begin
          logic [2*W-1:0] e;
          e = ref_q.pop_front();
          chk({dout_re, dout_im} == e, "R5 output data", {dout_re, dout_im}, e);
        end
      end else if (run_len != 0) begin
        last_run = run_len;
        run_len = 0;
      end
      exp_vld = rd_en && dout_rdy && !start;
      if (din_vld && load_rdy && !start) begin
        ref_q.push_back({din_re, din_im});
        acc_cnt++;
      end
    end
  end

  task automatic feed(input logic [15:0] pat);
    int i = 0;
    forever begin
      @(posedge clk); #1;
      if (acc_cnt >= tgt_in) break;
      din_vld = pat[i % 16];
      din_re  = W'($urandom);
      din_im  = W'($urandom);
      i++;
    end
    din_vld = 1'b0;
  endtask

  task automatic drain(input logic [15:0] pat);
    int i = 0;
    forever begin
      @(posedge clk); #1;
      if (out_cnt >= tgt_out) break;
      rd_en = pat[i % 16];
      i++;
    end
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(load_rdy == 1'b1, "R1 reset load_rdy", load_rdy, 1);
    chk(dout_rdy == 1'b0, "R1 reset dout_rdy", dout_rdy, 0);
    chk(dout_vld == 1'b0, "R1 reset dout_vld", dout_vld, 0);
    chk(pong == 1'b0, "R1 reset pong", pong, 0);
    rst_n = 1'b1;

    // R9: reads with no frame ready produce nothing
    @(posedge clk); #1; rd_en = 1'b1;
    repeat (5) @(posedge clk);
    #1; rd_en = 1'b0;
    @(negedge clk);
    chk(out_cnt == 0, "R9 reads while not ready", out_cnt, 0);

    // table walk: gapped loads (R2) against paced reads (R7)
    for (int v = 0; v < NV; v++) begin
      tgt_in  += 2*N;
      tgt_out += 2*N;
      fork
        feed(IN_PAT[v]);
        drain(RD_PAT[v]);
      join
      repeat (4) @(posedge clk);
    end
    @(negedge clk);
    chk(ref_q.size() == 0, "R5 queue empty after table", ref_q.size(), 0);
    chk(dout_rdy == 1'b0, "R8 rdy low after drain", dout_rdy, 0);

    // R4/R6: three frames with no reads
    tgt_in += 3*N;
    feed(16'hFFFF);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(load_rdy == 1'b0, "R4 both banks held", load_rdy, 0);
    chk(pong == 1'b1, "R6 engine on bank 1", pong, 1);
    chk(dout_rdy == 1'b1, "R5 frame ready", dout_rdy, 1);
    // R3: samples while not ready are dropped
    @(posedge clk); #1; din_vld = 1'b1; din_re = 8'hA5; din_im = 8'h5A;
    repeat (10) @(posedge clk);
    #1; din_vld = 1'b0;
    @(negedge clk);
    chk(ref_q.size() == 3*N, "R3 ignored samples", ref_q.size(), 3*N);
    chk(load_rdy == 1'b0, "R3 still not ready", load_rdy, 0);

    // R10/R8: continuous read
    tgt_out += 3*N;
    drain(16'hFFFF);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(last_run == N, "R10 burst length", last_run, N);
    chk(ref_q.size() == 0, "R5 queue empty after bursts", ref_q.size(), 0);
    chk(dout_rdy == 1'b0, "R8 rdy cleared", dout_rdy, 0);
    chk(load_rdy == 1'b1, "R4 ready again", load_rdy, 1);
    chk(pong == 1'b0, "R6 idle pong", pong, 0);

    // R1: start pulse mid-frame
    tgt_in += N + 3;
    feed(16'hFFFF);
    repeat (30) @(posedge clk);
    #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    ref_q.delete();
    tgt_in = acc_cnt; tgt_out = out_cnt;
    @(negedge clk);
    chk(load_rdy == 1'b1, "R1 start load_rdy", load_rdy, 1);
    chk(dout_rdy == 1'b0, "R1 start dout_rdy", dout_rdy, 0);
    chk(pong == 1'b0, "R1 start pong", pong, 0);
    tgt_in += 2*N; tgt_out += 2*N;
    fork
      feed(16'h6DB6);
      drain(16'h9249);
    join
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ref_q.size() == 0, "R1 frames after start", ref_q.size(), 0);
    summary();
  end
endmodule